// File: doc/BRIEF.md
# Segment-Test Corner Flag Detector

This block decides, for one candidate pixel per lane, whether that pixel is a corner. Each lane receives the candidate's own intensity together with the intensities of the sixteen pixels on a discrete circle of radius three around it. All lanes share one programmable threshold and one valid strobe. A ring pixel counts as brighter when it lies strictly above the candidate plus the threshold. It counts as darker when it lies strictly below the candidate minus the threshold. Both bounds saturate at the ends of the pixel range.

The brighter results form one 16-bit vector and the darker results form another. Each vector is compared in parallel against the sixteen rotations of a nine-ones, seven-zeros pattern. A match on either vector marks the candidate as a corner. The lane count is a power-of-two parameter (1, 2, 4 or 8, with 4 as the default), so several pixels of a fast raster stream can be judged in each clock. Building the window from the stream, scoring and suppression of neighbours happen in other blocks.

Top module: `corner_seg_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `out_corner` is all zeros.
- R2: Ring pixel i of a lane counts as brighter when its value exceeds the candidate plus the threshold. The upper bound saturates at the maximum pixel value, so when candidate plus threshold reaches or passes that value, no pixel counts as brighter.
- R3: Ring pixel i counts as darker when its value is below the candidate minus the threshold. The lower bound saturates at 0, so when the threshold reaches or passes the candidate, no pixel counts as darker.
- R4: A ring pixel equal to either bound is neither brighter nor darker.
- R5: Ring pixel i of lane l sits at bits `ring[(l*16+i)*PIX_W +: PIX_W]` and the candidate at `centre[l*PIX_W +: PIX_W]`. Ring indices 15 and 0 are adjacent, so a run of nine or more ones that wraps from index 15 to index 0 qualifies.
- R6: A vector whose longest circular run of ones is eight or shorter does not qualify, even when it holds more than eight ones in total.
- R7: A lane is flagged when its brighter vector or its darker vector qualifies. Eight brighter and eight darker pixels together do not flag it.
- R8: `out_valid` equals `in_valid` delayed by exactly two clocks. `out_corner` in that cycle belongs to the inputs sampled with that strobe.
- R9: Lanes are independent. Lane l of `out_corner` depends only on lane l's candidate and ring pixels and on the shared threshold.
- R10: With a zero threshold and every ring pixel equal to the candidate, the lane's flag is 0.
- R11: `out_corner` is all zeros in every cycle in which `out_valid` is 0.
- R12: A candidate of 209 with threshold 20, fourteen ring pixels below 189 forming a circular run of 14 and none above 229, is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe marking the candidates of all lanes as present |
| threshold | input | PIX_W | Shared intensity threshold |
| centre | input | LANES*PIX_W | Candidate intensity per lane |
| ring | input | LANES*16*PIX_W | Sixteen ring intensities per lane |
| out_valid | output | 1 | Strobe aligned with the flags, two clocks after `in_valid` |
| out_corner | output | LANES | Corner flag per lane |

## Verification
A new set of candidates enters the comparison stage in the same cycle that the previous set is matched against the arc patterns, and a third set leaves. Back-to-back strobes are mixed with idle gaps, and different lanes in one cycle get different outcomes (bright arc, dark arc, wrapped arc, eight-long arc, clamped bound). This shows whether results cross between pipeline stages or between lanes. Every cycle, the outputs are compared against a behavioural model that holds expected strobe and flag pairs in a two-deep queue. The model computes each flag by measuring the longest circular run directly, not by pattern matching.

// File: rtl/corner_pkg.sv
package corner_pkg;

    localparam int RING_N = 16;
    localparam int ARC_N  = 9;

    // Rotation s of the arc template: ARC_N ones starting at ring index s,
    // wrapping past the last index back to index 0.
    function automatic logic [RING_N-1:0] arc_template(input int start);
        logic [RING_N-1:0] pat;
        pat = '0;
        for (int k = 0; k < ARC_N; k++) begin
            pat[(start + k) % RING_N] = 1'b1;
        end
        return pat;
    endfunction

endpackage

// File: rtl/corner_bounds.sv
module corner_bounds #(
    parameter int PIX_W = 8
) (
    input  logic [PIX_W-1:0] centre,
    input  logic [PIX_W-1:0] threshold,
    output logic [PIX_W-1:0] upper,
    output logic [PIX_W-1:0] lower
);

    localparam logic [PIX_W-1:0] PIX_MAX = '1;

    logic [PIX_W:0] sum_w;
    logic [PIX_W:0] diff_w;

    always_comb begin
        sum_w  = {1'b0, centre} + {1'b0, threshold};
        diff_w = {1'b0, centre} - {1'b0, threshold};
        upper  = sum_w[PIX_W]  ? PIX_MAX : sum_w[PIX_W-1:0];
        lower  = diff_w[PIX_W] ? '0      : diff_w[PIX_W-1:0];
    end

endmodule

// File: rtl/corner_ring_compare.sv
module corner_ring_compare #(
    parameter int PIX_W  = 8,
    parameter int RING_N = 16
) (
    input  logic [RING_N*PIX_W-1:0] ring,
    input  logic [PIX_W-1:0]        upper,
    input  logic [PIX_W-1:0]        lower,
    output logic [RING_N-1:0]       brighter,
    output logic [RING_N-1:0]       darker
);

    for (genvar i = 0; i < RING_N; i++) begin : g_pix
        logic [PIX_W-1:0] px;
        assign px          = ring[i*PIX_W +: PIX_W];
        assign brighter[i] = px > upper;
        assign darker[i]   = px < lower;
    end

endmodule

// File: rtl/corner_arc_match.sv
module corner_arc_match
    import corner_pkg::*;
(
    input  logic [RING_N-1:0] vec,
    output logic              hit
);

    logic [RING_N-1:0] rot_hit;

    for (genvar s = 0; s < RING_N; s++) begin : g_rot
        localparam logic [RING_N-1:0] PAT = arc_template(s);
        assign rot_hit[s] = (vec & PAT) == PAT;
    end

    assign hit = |rot_hit;

endmodule

// File: rtl/corner_seg_detect.sv
module corner_seg_detect
    import corner_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [PIX_W-1:0]              threshold,
    input  logic [LANES*PIX_W-1:0]        centre,
    input  logic [LANES*RING_N*PIX_W-1:0] ring,
    output logic                          out_valid,
    output logic [LANES-1:0]              out_corner
);

    localparam int LANE_RING_W = RING_N * PIX_W;

    typedef struct packed {
        logic                           cmp_v;
        logic [LANES-1:0][RING_N-1:0]   br;
        logic [LANES-1:0][RING_N-1:0]   dk;
        logic                           res_v;
        logic [LANES-1:0]               flag;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [LANES-1:0][RING_N-1:0] br_w, dk_w;
    logic [LANES-1:0]             br_hit, dk_hit;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [PIX_W-1:0] upper_w, lower_w;

        corner_bounds #(.PIX_W(PIX_W)) i_bounds (
            .centre    (centre[l*PIX_W +: PIX_W]),
            .threshold (threshold),
            .upper     (upper_w),
            .lower     (lower_w)
        );

        corner_ring_compare #(.PIX_W(PIX_W), .RING_N(RING_N)) i_cmp (
            .ring     (ring[l*LANE_RING_W +: LANE_RING_W]),
            .upper    (upper_w),
            .lower    (lower_w),
            .brighter (br_w[l]),
            .darker   (dk_w[l])
        );

        corner_arc_match i_match_br (
            .vec (pipe_q.br[l]),
            .hit (br_hit[l])
        );

        corner_arc_match i_match_dk (
            .vec (pipe_q.dk[l]),
            .hit (dk_hit[l])
        );
    end

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.cmp_v = in_valid;
        pipe_d.br    = in_valid ? br_w : '0;
        pipe_d.dk    = in_valid ? dk_w : '0;
        pipe_d.res_v = pipe_q.cmp_v;
        pipe_d.flag  = pipe_q.cmp_v ? (br_hit | dk_hit) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.res_v;
    assign out_corner = pipe_q.flag;

endmodule

// File: rtl/corner_seg_detect_chk.sv
module corner_seg_detect_chk #(
    parameter int LANES = 4,
    parameter int PIX_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic [PIX_W-1:0]           threshold,
    input logic [LANES*PIX_W-1:0]     centre,
    input logic [LANES*16*PIX_W-1:0]  ring,
    input logic                       out_valid,
    input logic [LANES-1:0]           out_corner
);

    logic v1_q, v2_q;
    logic flat0, extreme0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
        end
    end

    always_comb begin
        flat0    = 1'b1;
        extreme0 = (centre[PIX_W-1:0] == '0) && (threshold != '1);
        for (int i = 0; i < 16; i++) begin
            if (ring[i*PIX_W +: PIX_W] != centre[PIX_W-1:0]) flat0 = 1'b0;
            if (ring[i*PIX_W +: PIX_W] != '1) extreme0 = 1'b0;
        end
    end

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2_q);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_corner == '0);

    // R10
    flat_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && threshold == '0 && flat0) |=> ##1 !out_corner[0]);

    // R2
    all_bright_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && extreme0) |=> ##1 out_corner[0]);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_corner == '0));

endmodule

bind corner_seg_detect corner_seg_detect_chk #(.LANES(LANES), .PIX_W(PIX_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .threshold  (threshold),
    .centre     (centre),
    .ring       (ring),
    .out_valid  (out_valid),
    .out_corner (out_corner)
);

// File: tb/test_corner_seg_detect.sv
`timescale 1ns/1ps
module test_corner_seg_detect;

    localparam int LANES = 4;
    localparam int PIX_W = 8;

    logic                         clk = 1'b0;
    logic                         rst_n = 1'b0;
    logic                         in_valid = 1'b0;
    logic [PIX_W-1:0]             threshold = '0;
    logic [LANES*PIX_W-1:0]       centre;
    logic [LANES*16*PIX_W-1:0]    ring;
    logic                         out_valid;
    logic [LANES-1:0]             out_corner;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] cen_a [LANES];
    logic [7:0] pix_a [LANES][16];
    logic [7:0] nx_cen [LANES];
    logic [7:0] nx_pix [LANES][16];
    logic [7:0] nx_thr = '0;

    logic [LANES:0] exp_q [$];
    string          tag_q [$];

    always #4 clk = ~clk;

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            centre[l*PIX_W +: PIX_W] = cen_a[l];
            for (int i = 0; i < 16; i++) begin
                ring[(l*16+i)*PIX_W +: PIX_W] = pix_a[l][i];
            end
        end
    end

    corner_seg_detect #(.LANES(LANES), .PIX_W(PIX_W)) i_corner_seg_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .threshold  (threshold),
        .centre     (centre),
        .ring       (ring),
        .out_valid  (out_valid),
        .out_corner (out_corner)
    );

    function automatic int longest_run(input bit [15:0] v);
        int best = 0;
        int run = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i % 16]) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        return best;
    endfunction

    function automatic bit model_lane(input int l);
        int hi, lo;
        bit [15:0] b, d;
        hi = int'(nx_cen[l]) + int'(nx_thr);
        if (hi > 255) hi = 255;
        lo = int'(nx_cen[l]) - int'(nx_thr);
        if (lo < 0) lo = 0;
        for (int i = 0; i < 16; i++) begin
            b[i] = int'(nx_pix[l][i]) > hi;
            d[i] = int'(nx_pix[l][i]) < lo;
        end
        return (longest_run(b) >= 9) || (longest_run(d) >= 9);
    endfunction

    task automatic check(input string tag, input logic [LANES:0] act, input logic [LANES:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: valid/flags actual %b expected %b", tag, act, exp);
        end
    endtask

    // one cycle: compare outputs, then apply the staged inputs
    task automatic step(input string tag, input bit v);
        logic [LANES:0] e;
        logic [LANES-1:0] f;
        @(negedge clk);
        e = exp_q.pop_front();
        check(tag_q.pop_front(), {out_valid, out_corner}, e);
        f = '0;
        if (v) for (int l = 0; l < LANES; l++) f[l] = model_lane(l);
        exp_q.push_back({v, f});
        tag_q.push_back(v ? tag : "R11");
        in_valid  = v;
        threshold = nx_thr;
        for (int l = 0; l < LANES; l++) begin
            cen_a[l] = nx_cen[l];
            for (int i = 0; i < 16; i++) pix_a[l][i] = nx_pix[l][i];
        end
    endtask

    task automatic set_lane(input int l, input int c, input bit [15:0] bm, input bit [15:0] dm);
        nx_cen[l] = 8'(c);
        for (int i = 0; i < 16; i++) begin
            if (bm[i])      nx_pix[l][i] = 8'(c + nx_thr + 1);
            else if (dm[i]) nx_pix[l][i] = 8'(c - nx_thr - 1);
            else            nx_pix[l][i] = 8'(c);
        end
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) begin
            cen_a[l] = '0; nx_cen[l] = '0;
            for (int i = 0; i < 16; i++) begin pix_a[l][i] = '0; nx_pix[l][i] = '0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {out_valid, out_corner}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {out_valid, out_corner}, '0);
        exp_q.push_back('0); tag_q.push_back("R1");
        exp_q.push_back('0); tag_q.push_back("R1");

        // R10 zero threshold, flat ring, and lane 1 one step off
        nx_thr = 8'd0;
        set_lane(0, 80, '0, '0);
        set_lane(1, 80, 16'h01FF, '0);
        set_lane(2, 200, '0, 16'hFF80);
        set_lane(3, 7, '0, '0);
        step("R10", 1);

        // R5 wrapped run of nine, R6 two runs of eight, R9 mixed lanes
        nx_thr = 8'd15;
        set_lane(0, 100, 16'hF80F, '0);
        set_lane(1, 100, '0, 16'hF00F);
        set_lane(2, 100, 16'hFF00, 16'h00FF);
        set_lane(3, 100, 16'h7F7F, '0);
        step("R5", 1);

        // R7 bright only, dark only, mixed; R6 long but broken
        set_lane(0, 120, 16'h0FF8, '0);
        set_lane(1, 120, '0, 16'h3FE0);
        set_lane(2, 120, 16'h00F0, 16'hFF0F);
        set_lane(3, 120, '0, 16'hEFEF);
        step("R7", 1);
        step("R8", 0);

        // R4 pixels exactly on the bounds
        nx_thr = 8'd10;
        for (int l = 0; l < LANES; l++) nx_cen[l] = 8'd100;
        for (int i = 0; i < 16; i++) begin
            nx_pix[0][i] = 8'd110;
            nx_pix[1][i] = 8'd90;
            nx_pix[2][i] = (i < 9) ? 8'd111 : 8'd110;
            nx_pix[3][i] = (i > 6) ? 8'd89 : 8'd90;
        end
        step("R4", 1);

        // R2 / R3 clamped bounds
        nx_thr = 8'd20;
        nx_cen[0] = 8'd250; nx_cen[1] = 8'd10; nx_cen[2] = 8'd234; nx_cen[3] = 8'd21;
        for (int i = 0; i < 16; i++) begin
            nx_pix[0][i] = 8'd255;
            nx_pix[1][i] = 8'd0;
            nx_pix[2][i] = 8'd255;
            nx_pix[3][i] = 8'd0;
        end
        step("R2", 1);
        nx_thr = 8'd255;
        step("R3", 1);

        // R12 worked example on lane 0, others idle
        nx_thr = 8'd20;
        nx_cen[0] = 8'd209;
        for (int i = 0; i < 16; i++) nx_pix[0][i] = (i == 5 || i == 6) ? 8'd209 : 8'd150;
        for (int l = 1; l < LANES; l++) set_lane(l, 50, '0, '0);
        step("R12", 1);

        // R9 random lanes, back-to-back and gapped strobes
        for (int n = 0; n < 300; n++) begin
            nx_thr = 8'($urandom_range(0, 40));
            for (int l = 0; l < LANES; l++) begin
                if ($urandom_range(0, 1) == 0) begin
                    set_lane(l, $urandom_range(45, 210), 16'($urandom), '0);
                    if ($urandom_range(0, 1) == 0) begin
                        for (int i = 0; i < 16; i++) nx_pix[l][i] = 8'($urandom);
                    end
                end else begin
                    set_lane(l, $urandom_range(45, 210), '0, 16'($urandom) | 16'h01FF);
                end
            end
            step("R9", $urandom_range(0, 3) != 0);
        end
        step("R8", 0);
        step("R8", 0);
        step("R11", 0);
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule